// File: doc/BRIEF.md
# Double-Buffered Serial Block Receiver

This block takes a compressed byte stream that arrives one bit at a time on a serial data line with its own bit clock. It packs the bits into bytes and stores them in two equal buffers that are used in turn. A downstream consumer pulls the bytes out through a byte-wide valid/ready port. The consumer empties one buffer completely before it moves to the other.

Flow control works on whole blocks and not on single bytes. Each time the reader frees a buffer, the block raises `demand_pulse` for one system clock. The external controller answers each pulse by sending exactly one block of `BLOCK_BYTES` bytes. So the pulse rate follows the average consumption rate and does not depend on the serial bit clock.

After reset both buffers are empty. The block asks for the first two blocks on its own, one pulse per buffer. Bytes that arrive while both buffers hold unread data are discarded, and a sticky flag records the loss. `BLOCK_BYTES` must be a power of two.

Top module: `blk_serial_rx`

## Requirements
- R1: While `rst` is high, `demand_pulse`, `rd_valid` and `overflow` are all low.
- R2: After reset is released, and before any data is sent, exactly two demand pulses appear: one in the first cycle after release and one in the third. Buffer 0 is filled first, then buffer 1.
- R3: Serial bits are sampled on rising edges of `ser_clk` and packed most significant bit first. Every eighth bit forms one byte.
- R4: Bytes leave `rd_data` in the order they arrived. A block of `BLOCK_BYTES` bytes fills one buffer, and the two buffers are filled and drained alternately, starting with buffer 0.
- R5: `rd_valid` is high only while a byte that has been received but not yet taken is presented. It falls only in the cycle after a transfer (`rd_valid` and `rd_ready` both high). With nothing stored it stays low.
- R6: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` stays unchanged.
- R7: Each buffer that is drained produces exactly one `demand_pulse`, one system clock wide. The pulse is raised when the last byte of that buffer is moved into the output register. No pulse is raised while a buffer still holds unread bytes.
- R8: A byte that completes while both buffers are full is discarded. It never appears on `rd_data`, and `overflow` goes high and stays high until reset.
- R9: The demand pulse count depends only on the number of blocks consumed, not on the bit clock rate. Any bit clock whose high and low phases each last at least `SYNC_STAGES`+1 system clocks is accepted, which covers 1.4 MHz at system clocks of about 10 MHz and above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to `clk` |
| ser_dat | input | 1 | Serial data bit, sampled on the rising edge of `ser_clk` |
| demand_pulse | output | 1 | One-cycle request for one new block |
| rd_data | output | DATA_W | Byte presented to the consumer |
| rd_valid | output | 1 | `rd_data` holds an unread byte |
| rd_ready | input | 1 | Consumer takes the byte when `rd_valid` is also high |
| overflow | output | 1 | Sticky flag: a byte was dropped because both buffers were full |

## Verification
Two events can land in the same system cycle. One is a byte strobe that completes the fill of one buffer. The other is the reader fetching the last byte of the other buffer, which also triggers a demand pulse. Both events update the per-buffer full flags in that one cycle.

The bench fills buffer 0 with the consumer stalled and sends the second block up to its final bit. It then releases the consumer and delays the final bit clock edge by 0 to 15 cycles, so the two events sweep across each other. In every trial the bench checks that all sixteen bytes come out in order, that exactly two demand pulses are produced, and that no byte is lost or repeated.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [1:0] {
    INIT_FIRST  = 2'd0,
    INIT_GAP    = 2'd1,
    INIT_SECOND = 2'd2,
    INIT_DONE   = 2'd3
  } init_state_t;
endpackage

// File: rtl/sbi_sync.sv
module sbi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sbi_deser.sv
module sbi_deser #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              byte_stb,
  output logic [DATA_W-1:0] byte_out
);
  localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  logic sclk_s, sdat_s, sclk_prev_q, rise;
  logic [BCW-1:0]    bit_cnt_q;
  logic [DATA_W-1:0] shift_q, shift_nxt;
  logic              stb_q;
  logic [DATA_W-1:0] byte_q;

  sbi_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst(rst), .d(ser_clk), .q(sclk_s)
  );
  sbi_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst(rst), .d(ser_dat), .q(sdat_s)
  );

  assign rise      = sclk_s & ~sclk_prev_q;
  assign shift_nxt = {shift_q[DATA_W-2:0], sdat_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b0;
      bit_cnt_q   <= '0;
      shift_q     <= '0;
      stb_q       <= 1'b0;
      byte_q      <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      stb_q       <= 1'b0;
      if (rise) begin
        shift_q <= shift_nxt;
        if (bit_cnt_q == LAST_BIT) begin
          bit_cnt_q <= '0;
          stb_q     <= 1'b1;
          byte_q    <= shift_nxt;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_stb = stb_q;
  assign byte_out = byte_q;
endmodule

// File: rtl/sbi_buf_mem.sv
module sbi_buf_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4096,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/sbi_ctrl.sv
module sbi_ctrl
  import sbi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BLOCK_BYTES = 2048,
  parameter int CW          = $clog2(BLOCK_BYTES),
  parameter int AW          = CW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              rd_ready,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic              demand_pulse,
  output logic              overflow
);
  localparam logic [CW-1:0] LAST_IDX = CW'(BLOCK_BYTES - 1);

  logic [1:0]    full_q;
  logic          fill_sel_q, drain_sel_q;
  logic [CW-1:0] fill_cnt_q, drain_cnt_q;
  logic          valid_q, demand_q, ovf_q;
  init_state_t   init_q;
  logic          fill_done, drain_done, drop;

  assign wr_en      = byte_stb & ~full_q[fill_sel_q];
  assign drop       = byte_stb &  full_q[fill_sel_q];
  assign wr_addr    = {fill_sel_q, fill_cnt_q};
  assign wr_data    = byte_in;
  assign fill_done  = wr_en & (fill_cnt_q == LAST_IDX);

  assign rd_en      = full_q[drain_sel_q] & (~valid_q | rd_ready);
  assign rd_addr    = {drain_sel_q, drain_cnt_q};
  assign drain_done = rd_en & (drain_cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_sel_q <= 1'b0;
      fill_cnt_q <= '0;
    end else if (wr_en) begin
      fill_cnt_q <= fill_done ? '0 : fill_cnt_q + 1'b1;
      if (fill_done) fill_sel_q <= ~fill_sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_sel_q <= 1'b0;
      drain_cnt_q <= '0;
    end else if (rd_en) begin
      drain_cnt_q <= drain_done ? '0 : drain_cnt_q + 1'b1;
      if (drain_done) drain_sel_q <= ~drain_sel_q;
    end
  end

  generate
    for (genvar b = 0; b < 2; b++) begin : g_full
      always_ff @(posedge clk) begin
        if (rst) begin
          full_q[b] <= 1'b0;
        end else if (fill_done && (fill_sel_q == b[0])) begin
          full_q[b] <= 1'b1;
        end else if (drain_done && (drain_sel_q == b[0])) begin
          full_q[b] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (rd_en) begin
      valid_q <= 1'b1;
    end else if (rd_ready) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q   <= INIT_FIRST;
      demand_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (init_q != INIT_DONE) init_q <= init_state_t'(init_q + 2'd1);
      demand_q <= drain_done | (init_q == INIT_FIRST) | (init_q == INIT_SECOND);
      ovf_q    <= ovf_q | drop;
    end
  end

  assign rd_valid     = valid_q;
  assign demand_pulse = demand_q;
  assign overflow     = ovf_q;
endmodule

// File: rtl/blk_serial_rx.sv
module blk_serial_rx #(
  parameter int DATA_W      = 8,
  parameter int BLOCK_BYTES = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              demand_pulse,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              overflow
);
  localparam int CW    = $clog2(BLOCK_BYTES);
  localparam int AW    = CW + 1;
  localparam int DEPTH = 2 * BLOCK_BYTES;

  logic              byte_stb;
  logic [DATA_W-1:0] byte_val;
  logic              wr_en, rd_en;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data;

  sbi_deser #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_deser (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .byte_stb(byte_stb), .byte_out(byte_val)
  );

  sbi_ctrl #(.DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES), .CW(CW), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_in(byte_val),
    .rd_ready(rd_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .demand_pulse(demand_pulse), .overflow(overflow)
  );

  sbi_buf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(rd_data)
  );
endmodule

// File: rtl/blk_serial_rx_chk.sv
module blk_serial_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              demand_pulse,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              overflow
);
  AST_DEMAND_SINGLE: assert property (@(posedge clk) disable iff (rst)
    demand_pulse |=> !demand_pulse); // R7

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R6

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R8

  AST_VALID_FALLS_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_valid) |-> $past(rd_ready)); // R5
endmodule

bind blk_serial_rx blk_serial_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .demand_pulse(demand_pulse), .rd_data(rd_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .overflow(overflow)
);

// File: tb/blk_serial_rx_tb_top.sv
`timescale 1ns/1ps
module blk_serial_rx_tb_top;
  localparam int BB = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, rd_ready = 1'b0;
  logic demand_pulse, rd_valid, overflow;
  logic [7:0] rd_data;

  int errs = 0, checks = 0;
  int exp_q[$];
  int rx_cnt = 0, dem_cnt = 0, exp_dem = 0;
  logic dem_prev = 1'b0, stall_prev = 1'b0;
  logic [7:0] stall_data = '0;
  bit done = 0;

  always #2 clk = ~clk;

  blk_serial_rx #(.DATA_W(8), .BLOCK_BYTES(BB), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .demand_pulse(demand_pulse), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (demand_pulse) begin
        dem_cnt++;
        if (dem_prev) check(0, "R7 pulse width", 2, 1);
      end
      dem_prev = demand_pulse;
      if (stall_prev)
        check(rd_valid && rd_data == stall_data, "R6 hold", int'(rd_data), int'(stall_data));
      stall_prev = rd_valid && !rd_ready;
      stall_data = rd_data;
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) check(0, "R5 valid without data", int'(rd_data), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(int'(rd_data) == e, "R3 R4 byte order", int'(rd_data), e);
        end
        rx_cnt++;
      end
    end
  end

  task automatic send_bit(input logic b, input int half);
    ser_dat = b; ser_clk = 1'b0;
    repeat (half) @(posedge clk); #1;
    ser_clk = 1'b1;
    repeat (half) @(posedge clk); #1;
  endtask

  task automatic send_byte(input logic [7:0] v, input int half, input bit keep);
    for (int i = 7; i >= 0; i--) send_bit(v[i], half);
    ser_clk = 1'b0;
    if (keep) exp_q.push_back(int'(v));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    check(!demand_pulse && !rd_valid && !overflow, "R1 reset outputs",
          {demand_pulse, rd_valid, overflow}, 0);
    rst = 1'b0;
    wait_cyc(12);
    exp_dem = 2;
    check(dem_cnt == exp_dem, "R2 startup pulses", dem_cnt, exp_dem);

    // Fill both buffers with consumer stalled
    for (int i = 0; i < 2*BB; i++) send_byte(8'((i*37 + 5) & 255), 4, 1);
    wait_cyc(8);
    check(rd_valid == 1'b1, "R5 valid with stored data", rd_valid, 1);
    check(rd_data == 8'd5, "R3 first byte msb first", rd_data, 5);
    check(dem_cnt == exp_dem, "R7 no pulse before drain", dem_cnt, exp_dem);
    check(overflow == 1'b0, "R8 no overflow yet", overflow, 0);
    for (int i = 0; i < 4; i++) send_byte(8'(8'hE0 + i), 4, 0);
    wait_cyc(8);
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    rd_ready = 1'b1;
    wait_cyc(40);
    exp_dem += 2;
    check(rx_cnt == 2*BB, "R8 dropped bytes absent", rx_cnt, 2*BB);
    check(rd_valid == 1'b0, "R5 valid low when empty", rd_valid, 0);
    check(dem_cnt == exp_dem, "R7 pulse per drained buffer", dem_cnt, exp_dem);
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);

    // Stall pattern on the read side
    rd_ready = 1'b0;
    for (int i = 0; i < BB; i++) send_byte(8'(8'h80 | i*3), 4, 1);
    for (int k = 0; k < 40; k++) begin
      rd_ready = (k % 3 == 2);
      wait_cyc(1);
    end
    rd_ready = 1'b1;
    wait_cyc(20);
    exp_dem += 1;
    check(rx_cnt == 3*BB, "R6 all bytes after stalls", rx_cnt, 3*BB);
    check(dem_cnt == exp_dem, "R7 single block drained", dem_cnt, exp_dem);

    // Slow bit clock, streaming consumer
    for (int i = 0; i < 3*BB; i++) send_byte(8'((i*11 + 90) & 255), 12, 1);
    wait_cyc(30);
    exp_dem += 3;
    check(rx_cnt == 6*BB, "R9 slow clock bytes", rx_cnt, 6*BB);
    check(dem_cnt == exp_dem, "R9 pulses follow blocks", dem_cnt, exp_dem);

    // Sweep: fill completion against last read of the other buffer
    for (int d = 0; d < 16; d++) begin
      int base;
      logic [7:0] lastv;
      base = rx_cnt;
      rd_ready = 1'b0;
      for (int i = 0; i < 2*BB-1; i++) send_byte(8'(((d*16 + i)*29 + 3) & 255), 4, 1);
      lastv = 8'(((d*16 + 2*BB-1)*29 + 3) & 255);
      for (int i = 7; i >= 1; i--) send_bit(lastv[i], 4);
      ser_dat = lastv[0]; ser_clk = 1'b0;
      repeat (4) @(posedge clk); #1;
      rd_ready = 1'b1;
      if (d > 0) wait_cyc(d);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
      exp_q.push_back(int'(lastv));
      wait_cyc(40);
      exp_dem += 2;
      check(rx_cnt - base == 2*BB, "R4 sweep byte count", rx_cnt - base, 2*BB);
      check(dem_cnt == exp_dem, "R7 sweep pulses", dem_cnt, exp_dem);
      check(rd_valid == 1'b0, "R5 sweep drained", rd_valid, 0);
    end

    rst = 1'b1;
    wait_cyc(2);
    check(!demand_pulse && !rd_valid && !overflow, "R1 second reset",
          {demand_pulse, rd_valid, overflow}, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule